// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This peripheral holds one 8-bit up-counter, advanced by a prescaler whose division ratio is chosen from eight power-of-two settings. The same counter serves two roles. In watchdog mode an overflow raises a reset request for a fixed number of cycles and reports which kind of reset is wanted. In interval mode an overflow raises an interrupt that stays high until software clears the flag that caused it.

Software reaches the block through a small 16-bit register port with two locations: the count and the control/status word. A write lands only when its upper byte carries the key that belongs to the location addressed, so a stray store cannot reprogram the timer. The port has no handshake. A write presented with `bus_wr` high completes on that clock edge, and there is no back-pressure. Reads are combinational from `bus_sel`.

Top module: `kwdt_top`

## Requirements
- R1: A write with `bus_sel`=0 loads `bus_wdata[7:0]` into the count only when `bus_wdata[15:8]` is 0x5A. Any other upper byte leaves every register unchanged.
- R2: A write with `bus_sel`=1 loads the control/status word only when `bus_wdata[15:8]` is 0xA5. Any other upper byte leaves every register unchanged. The control/status bit positions are: 7 run enable, 6 mode (1 watchdog, 0 interval), 5 reset kind, 4 watchdog overflow flag, 3 interval overflow flag, 2:0 clock select.
- R3: `bus_rdata` is {0x00, count} when `bus_sel`=0 and {0x00, control/status} when `bus_sel`=1.
- R4: After reset the count and the control/status word are zero, so clock select is code 0. `rst_req`, `rst_kind` and `tmr_irq` are low.
- R5: While running, the count advances once every 2^(5+code) clock cycles, for codes 0..7 (32 up to 4096 cycles). Starting from 0xFF, the overflow is seen exactly that many edges after the write that starts the count.
- R6: With the run bit clear the count holds its value. Setting the bit again resumes counting from the held value, with a full prescaler period to the next step.
- R7: In watchdog mode the 0xFF to 0x00 wrap sets bit 4, not bit 3. On that same edge `rst_req` rises and stays high for exactly 16 cycles, and `rst_kind` takes the value of bit 5.
- R8: In interval mode the wrap sets bit 3, not bit 4. `tmr_irq` is high exactly while bit 3 is set, and `rst_req` stays low.
- R9: Writing 0 to a flag bit in an accepted control/status write clears that flag. Writing 1 to a flag bit leaves it unchanged, so only an overflow can set a flag.
- R10: An accepted count write restarts the prescaler phase. The next step then comes a full period after that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Location select: 0 count, 1 control/status |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| bus_rdata | output | 16 | Read data for the selected location, upper byte zero |
| rst_req | output | 1 | Reset request pulse after a watchdog overflow |
| rst_kind | output | 1 | Reset kind captured at the last watchdog overflow |
| tmr_irq | output | 1 | Interval overflow interrupt |

## Verification
A wrong prescaler limit or a phase that is not restarted shows up as a flag that rises a few edges early or late. Because every overflow is timed from the write that armed it, the bench catches this on the exact edge, for every clock-select code. A key decoder that accepts a bad key changes the readback at once, with no cycles of delay. A flag register that takes a written 1, or a mode bit routed to the wrong flag, shows on the next read and on `tmr_irq` or `rst_req`. A wrong reset hold count only appears when `rst_req` falls, 16 cycles after the overflow.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int BUS_W = 16;
  localparam int REG_W = 8;
  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam logic [7:0] KEY_CTRL  = 8'hA5;

  typedef struct packed {
    logic       run;
    logic       wdog;
    logic       rsel;
    logic       wflag;
    logic       iflag;
    logic [2:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             wovf_set,
  input  logic             iovf_set,
  output ctrl_t            ctrl,
  output logic             cnt_we,
  output logic [REG_W-1:0] cnt_wdata
);
  logic [7:0] key;
  logic       ctrl_we;

  assign key       = bus_wdata[BUS_W-1:REG_W];
  assign ctrl_we   = bus_wr && bus_sel && (key == KEY_CTRL);
  assign cnt_we    = bus_wr && !bus_sel && (key == KEY_COUNT);
  assign cnt_wdata = bus_wdata[REG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl_we) begin
        ctrl.run     <= bus_wdata[7];
        ctrl.wdog    <= bus_wdata[6];
        ctrl.rsel    <= bus_wdata[5];
        ctrl.wflag   <= ctrl.wflag & bus_wdata[4];
        ctrl.iflag   <= ctrl.iflag & bus_wdata[3];
        ctrl.clk_sel <= bus_wdata[2:0];
      end
      if (wovf_set) ctrl.wflag <= 1'b1;
      if (iovf_set) ctrl.iflag <= 1'b1;
    end
  end

  // R2: a control write with the wrong key leaves the word untouched
  assert_ctrl_key_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel && key != KEY_CTRL && !wovf_set && !iovf_set) |=> $stable(ctrl));

  // R9: flags only rise from hardware overflow
  assert_wflag_hw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wovf_set) |=> !$rose(ctrl.wflag));
  assert_iflag_hw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!iovf_set) |=> !$rose(ctrl.iflag));
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int BASE_LOG2 = 5,
  parameter int SEL_N     = 8,
  localparam int SEL_W    = $clog2(SEL_N),
  localparam int PRE_W    = BASE_LOG2 + SEL_N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim_tab [SEL_N];
  logic [PRE_W-1:0] cur_lim;

  for (genvar g = 0; g < SEL_N; g++) begin : g_lim
    localparam longint unsigned LIMV = (64'd1 << (BASE_LOG2 + g)) - 64'd1;
    assign lim_tab[g] = LIMV[PRE_W-1:0];
  end

  assign cur_lim = lim_tab[clk_sel];
  assign tick    = run && (pre >= cur_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre <= '0;
    else if (!run || restart) pre <= '0;
    else if (tick)            pre <= '0;
    else                      pre <= pre + 1'b1;
  end

  // R10: after a restart the next step is a full period away
  assert_restart_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [REG_W-1:0] cnt_wdata,
  input  logic             wdog,
  output logic [REG_W-1:0] cnt,
  output logic             wovf_set,
  output logic             iovf_set
);
  logic ovf;

  assign ovf      = tick && !cnt_we && (cnt == {REG_W{1'b1}});
  assign wovf_set = ovf && wdog;
  assign iovf_set = ovf && !wdog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_we) cnt <= cnt_wdata;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R6: without a step or a write the count holds
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt));
  // R5: a step at 0xFF wraps to zero
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wovf_set || iovf_set) |=> (cnt == '0));
  // R8: one overflow never sets both flags
  assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wovf_set && iovf_set));
endmodule

// File: rtl/kwdt_resp.sv
module kwdt_resp #(
  parameter int HOLD = 16,
  localparam int HW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wovf_set,
  input  logic rsel,
  output logic rst_req,
  output logic rst_kind
);
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      rst_kind <= 1'b0;
    end else if (wovf_set) begin
      hold     <= HW'(HOLD);
      rst_kind <= rsel;
    end else if (hold != '0) begin
      hold     <= hold - 1'b1;
    end
  end

  assign rst_req = (hold != '0);

  // R7: a watchdog overflow raises the request with the chosen kind
  assert_wd_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wovf_set |=> (rst_req && rst_kind == $past(rsel)));
  // R7: the kind only changes at an overflow
  assert_kind_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wovf_set |=> $stable(rst_kind));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int BASE_LOG2 = 5,
  parameter int SEL_N     = 8,
  parameter int RST_HOLD  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_sel,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req,
  output logic        rst_kind,
  output logic        tmr_irq
);
  ctrl_t            ctrl;
  logic             cnt_we;
  logic [REG_W-1:0] cnt_wdata;
  logic [REG_W-1:0] cnt;
  logic             wovf_set;
  logic             iovf_set;
  logic             tick;

  kwdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .wovf_set(wovf_set), .iovf_set(iovf_set),
    .ctrl(ctrl), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata)
  );

  kwdt_prescale #(.BASE_LOG2(BASE_LOG2), .SEL_N(SEL_N)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .restart(cnt_we),
    .clk_sel(ctrl.clk_sel), .tick(tick)
  );

  kwdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .wdog(ctrl.wdog), .cnt(cnt),
    .wovf_set(wovf_set), .iovf_set(iovf_set)
  );

  kwdt_resp #(.HOLD(RST_HOLD)) u_resp (
    .clk(clk), .rst_n(rst_n), .wovf_set(wovf_set), .rsel(ctrl.rsel),
    .rst_req(rst_req), .rst_kind(rst_kind)
  );

  assign tmr_irq   = ctrl.iflag;
  assign bus_rdata = {8'h00, bus_sel ? ctrl : cnt};

  // R8: an interval overflow never requests a reset
  assert_irq_no_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iovf_set && !rst_req) |=> !rst_req);
endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {sel, wdata, expected count read, expected control read}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'h5A12, 16'h0012, 16'h0000},
    {1'b0, 16'h5B34, 16'h0012, 16'h0000},
    {1'b1, 16'hA507, 16'h0012, 16'h0007},
    {1'b1, 16'h5A20, 16'h0012, 16'h0007},
    {1'b0, 16'hA533, 16'h0012, 16'h0007},
    {1'b1, 16'hA55A, 16'h0012, 16'h0042},
    {1'b0, 16'h5AFF, 16'h00FF, 16'h0042},
    {1'b1, 16'hA538, 16'h00FF, 16'h0020},
    {1'b0, 16'h5A00, 16'h0000, 16'h0020},
    {1'b1, 16'hA500, 16'h0000, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_req, rst_kind, tmr_irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
    .rst_kind(rst_kind), .tmr_irq(tmr_irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    bus_sel = sel;
    #1;
    v = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R4 reset state
    rd(1'b0, v); check("R4 count after reset", v, 16'h0000);
    rd(1'b1, v); check("R4 control after reset", v, 16'h0000);
    check("R4 outputs after reset", {13'd0, rst_req, rst_kind, tmr_irq}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R9 vector table: keys, layout, readback, written flags ignored
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][48], VEC[i][47:32]);
      rd(1'b0, v); check($sformatf("R1 R3 vec%0d count read", i), v, VEC[i][31:16]);
      rd(1'b1, v); check($sformatf("R2 R9 vec%0d control read", i), v, VEC[i][15:0]);
    end

    // R5 period for every clock-select code, R8 interval flag
    for (int k = 0; k < 8; k++) begin
      int d;
      d = 32 << k;
      wr(1'b1, 16'hA500);
      wr(1'b0, 16'h5AFF);
      wr(1'b1, 16'hA580 | 16'(k));
      wait_edges(d - 1);
      rd(1'b1, v); check($sformatf("R5 code%0d no flag one edge early", k), v, 16'h0080 | 16'(k));
      wait_edges(1);
      rd(1'b1, v); check($sformatf("R5 R8 code%0d interval flag on time", k), v, 16'h0088 | 16'(k));
    end
    check("R8 irq while flag set", {15'd0, tmr_irq}, 16'h0001);
    check("R8 no reset request in interval mode", {15'd0, rst_req}, 16'h0000);
    rd(1'b0, v); check("R5 count wrapped to zero", v, 16'h0000);

    // R9 clear by writing zero
    wr(1'b1, 16'hA500);
    rd(1'b1, v); check("R9 flag cleared by zero", v, 16'h0000);
    check("R8 irq drops with flag", {15'd0, tmr_irq}, 16'h0000);

    // R6 stop and resume
    wr(1'b0, 16'h5AF0);
    wr(1'b1, 16'hA580);
    wait_edges(96);
    rd(1'b0, v); check("R6 three steps counted", v, 16'h00F3);
    wr(1'b1, 16'hA500);
    wait_edges(200);
    rd(1'b0, v); check("R6 count holds while stopped", v, 16'h00F3);
    wr(1'b1, 16'hA580);
    wait_edges(31);
    rd(1'b0, v); check("R6 resume waits full period", v, 16'h00F3);
    wait_edges(1);
    rd(1'b0, v); check("R6 resume from held value", v, 16'h00F4);

    // R10 count write restarts the phase
    wr(1'b0, 16'h5AFF);
    wait_edges(20);
    wr(1'b0, 16'h5AFF);
    wait_edges(31);
    rd(1'b1, v); check("R10 no overflow before full period", v, 16'h0080);
    wait_edges(1);
    rd(1'b1, v); check("R10 overflow a full period after restart", v, 16'h0088);

    // R7 watchdog mode, reset kind 1
    wr(1'b1, 16'hA500);
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA5E0);
    wait_edges(31);
    check("R7 no request before overflow", {15'd0, rst_req}, 16'h0000);
    wait_edges(1);
    check("R7 request and kind at overflow", {14'd0, rst_req, rst_kind}, 16'h0003);
    rd(1'b1, v); check("R7 watchdog flag only", v, 16'h00F0);
    check("R7 no irq in watchdog mode", {15'd0, tmr_irq}, 16'h0000);
    wait_edges(15);
    check("R7 request held 16 cycles", {15'd0, rst_req}, 16'h0001);
    wait_edges(1);
    check("R7 request ends after 16 cycles", {15'd0, rst_req}, 16'h0000);

    // R7 reset kind 0
    wr(1'b1, 16'hA540);
    wr(1'b0, 16'h5AFF);
    wr(1'b1, 16'hA5C0);
    wait_edges(32);
    check("R7 kind zero captured", {14'd0, rst_req, rst_kind}, 16'h0002);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule